// File: doc/BRIEF.md
# Fracturable Sub-Word SIMD Multiplier

This block is one 32-bit lane of a vector multiply unit. On each cycle it accepts two 32-bit operands and a set of controls. The controls make it act as one 32x32 multiplier, as two independent 16x16 multipliers, or as four independent 8x8 multipliers. A signedness control picks two's-complement or unsigned arithmetic for every element. A half-select picks either the low or the high element-width bits of each element's double-width product. The element results are packed back into a single 32-bit word.

Inside, the work is done by four 18x18-sized and two 9x9-sized partial-product multipliers. Their operands are prepared according to the mode. In word mode all four wide products are summed with weights of 1, 2^16 and 2^32. In halfword mode two of them serve the two elements. In byte mode the lowest wide multiplier serves byte 0 and one cross-term multiplier serves byte 1, while the two narrow multipliers serve bytes 2 and 3. Each element has its own multiplier, so no carry moves between elements. The path is pipelined over three registers, and a valid flag travels with the data.

Top module: `simd_mul_lane`

## Requirements
- R1: With mode code 0 (word) and the high select at 0, the result is bits [31:0] of the 64-bit product of the two operands.
- R2: With mode code 0 and the high select at 1, the result is bits [63:32] of the 64-bit product. It is the signed product when the signed control is 1 and the unsigned product when it is 0.
- R3: With mode code 1 (halfword), element i (i = 0, 1) of the result sits at bits [16*i+15:16*i]. It is computed only from the operand bits in that same position, and no carry passes from element 0 into element 1.
- R4: With mode code 2 or 3 (byte), element i (i = 0..3) of the result sits at bits [8*i+7:8*i]. It is computed only from operand bits [8*i+7:8*i] of each operand. Codes 2 and 3 give identical results.
- R5: With the signed control at 1, every element operand is treated as two's complement. With it at 0, every element operand is treated as unsigned.
- R6: In the sub-word modes, the high select at 1 returns the upper element-width bits of each element's double-width product. The high select at 0 returns the lower element-width bits.
- R7: A result with out_valid high appears exactly 3 rising edges after the inputs are sampled with in_valid high. The edge that samples the inputs counts as the first. out_valid is low in every cycle that no such input produces.
- R8: While rst_n is low, out_valid and out_result are 0.
- R9: out_result keeps its last value in every cycle where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| in_a | input | 32 | First operand, packed elements |
| in_b | input | 32 | Second operand, packed elements |
| in_mode | input | 2 | 0 word, 1 halfword, 2 or 3 byte |
| in_signed | input | 1 | 1 two's complement, 0 unsigned |
| in_high | input | 1 | 1 upper half of each product, 0 lower half |
| out_valid | output | 1 | out_result holds a new packed result |
| out_result | output | 32 | Packed element results |

## Verification
Every operand set given with in_valid high is due at the outputs 3 rising edges later. The edge that samples it is the first of the three. Between such results the output must keep its value unchanged. The bench applies inputs on the falling edge and feeds each sampled set into a three-deep reference pipeline on the rising edge. On each falling edge it compares out_valid, and out_result when valid, with the oldest stage of that pipeline. This keeps every comparison on the cycle where the design's third register has just loaded. In cycles with no result, the bench checks that out_result still equals the previous result.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

  localparam int LANE_W   = 32;
  localparam int WIDE_W   = 18;
  localparam int NARROW_W = 9;
  localparam int NARROW_N = 2;

  typedef enum logic [1:0] {
    MODE_WORD  = 2'd0,
    MODE_HALF  = 2'd1,
    MODE_BYTE  = 2'd2,
    MODE_BYTE2 = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  sgn;
    logic  hi;
  } ctrl_t;

  function automatic logic is_byte(mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/smul_operand_prep.sv
module smul_operand_prep
  import simd_mul_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int WW = WIDE_W,
  parameter int NW = NARROW_W,
  parameter int NN = NARROW_N
) (
  input  logic [LW-1:0]         a,
  input  logic [LW-1:0]         b,
  input  ctrl_t                 ctrl,
  output logic [3:0][WW-1:0]    wa,
  output logic [3:0][WW-1:0]    wb,
  output logic [NN-1:0][NW-1:0] na,
  output logic [NN-1:0][NW-1:0] nb
);
  localparam int HW = LW / 2;
  localparam int BW = LW / 4;

  function automatic logic [WW-1:0] ext_h(logic [HW-1:0] v, logic s);
    return {{(WW-HW){s & v[HW-1]}}, v};
  endfunction

  function automatic logic [WW-1:0] ext_b(logic [BW-1:0] v, logic s);
    return {{(WW-BW){s & v[BW-1]}}, v};
  endfunction

  logic [HW-1:0] a_lo, a_hi, b_lo, b_hi;
  assign a_lo = a[HW-1:0];
  assign a_hi = a[LW-1:HW];
  assign b_lo = b[HW-1:0];
  assign b_hi = b[LW-1:HW];

  // index 0: low x low, 1: high(a) x low(b), 2: low(a) x high(b), 3: high x high
  always_comb begin
    wa = '0;
    wb = '0;
    unique case (ctrl.mode)
      MODE_WORD: begin
        wa[0] = ext_h(a_lo, 1'b0);       wb[0] = ext_h(b_lo, 1'b0);
        wa[1] = ext_h(a_hi, ctrl.sgn);   wb[1] = ext_h(b_lo, 1'b0);
        wa[2] = ext_h(a_lo, 1'b0);       wb[2] = ext_h(b_hi, ctrl.sgn);
        wa[3] = ext_h(a_hi, ctrl.sgn);   wb[3] = ext_h(b_hi, ctrl.sgn);
      end
      MODE_HALF: begin
        wa[0] = ext_h(a_lo, ctrl.sgn);   wb[0] = ext_h(b_lo, ctrl.sgn);
        wa[3] = ext_h(a_hi, ctrl.sgn);   wb[3] = ext_h(b_hi, ctrl.sgn);
      end
      default: begin
        wa[0] = ext_b(a[BW-1:0], ctrl.sgn);    wb[0] = ext_b(b[BW-1:0], ctrl.sgn);
        wa[1] = ext_b(a[2*BW-1:BW], ctrl.sgn); wb[1] = ext_b(b[2*BW-1:BW], ctrl.sgn);
      end
    endcase
  end

  for (genvar g = 0; g < NN; g++) begin : g_narrow
    localparam int POS = (2 + g) * BW;
    always_comb begin
      if (is_byte(ctrl.mode)) begin
        na[g] = {{(NW-BW){ctrl.sgn & a[POS+BW-1]}}, a[POS +: BW]};
        nb[g] = {{(NW-BW){ctrl.sgn & b[POS+BW-1]}}, b[POS +: BW]};
      end else begin
        na[g] = '0;
        nb[g] = '0;
      end
    end
  end

endmodule

// File: rtl/smul_partial_products.sv
module smul_partial_products
  import simd_mul_pkg::*;
#(
  parameter int WW = WIDE_W,
  parameter int NW = NARROW_W,
  parameter int NN = NARROW_N
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  ctrl_t                   in_ctrl,
  input  logic [3:0][WW-1:0]      wa,
  input  logic [3:0][WW-1:0]      wb,
  input  logic [NN-1:0][NW-1:0]   na,
  input  logic [NN-1:0][NW-1:0]   nb,
  output logic                    pp_valid,
  output ctrl_t                   pp_ctrl,
  output logic [3:0][2*WW-1:0]    wp,
  output logic [NN-1:0][2*NW-1:0] np
);
  // stage 1: operand registers
  logic                  s1_valid_q;
  ctrl_t                 s1_ctrl_q, s1_ctrl_d;
  logic [3:0][WW-1:0]    s1_wa_q, s1_wa_d, s1_wb_q, s1_wb_d;
  logic [NN-1:0][NW-1:0] s1_na_q, s1_na_d, s1_nb_q, s1_nb_d;

  always_comb begin
    s1_ctrl_d = s1_ctrl_q;
    s1_wa_d   = s1_wa_q;
    s1_wb_d   = s1_wb_q;
    s1_na_d   = s1_na_q;
    s1_nb_d   = s1_nb_q;
    if (in_valid) begin
      s1_ctrl_d = in_ctrl;
      s1_wa_d   = wa;
      s1_wb_d   = wb;
      s1_na_d   = na;
      s1_nb_d   = nb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_ctrl_q  <= '0;
      s1_wa_q    <= '0;
      s1_wb_q    <= '0;
      s1_na_q    <= '0;
      s1_nb_q    <= '0;
    end else begin
      s1_valid_q <= in_valid;
      s1_ctrl_q  <= s1_ctrl_d;
      s1_wa_q    <= s1_wa_d;
      s1_wb_q    <= s1_wb_d;
      s1_na_q    <= s1_na_d;
      s1_nb_q    <= s1_nb_d;
    end
  end

  // behavioural partial-product multipliers
  logic [3:0][2*WW-1:0]    wp_c;
  logic [NN-1:0][2*NW-1:0] np_c;

  for (genvar w = 0; w < 4; w++) begin : g_wide
    logic signed [2*WW-1:0] prod;
    assign prod    = $signed(s1_wa_q[w]) * $signed(s1_wb_q[w]);
    assign wp_c[w] = prod;
  end

  for (genvar n = 0; n < NN; n++) begin : g_nar
    logic signed [2*NW-1:0] prod;
    assign prod    = $signed(s1_na_q[n]) * $signed(s1_nb_q[n]);
    assign np_c[n] = prod;
  end

  // stage 2: product registers
  ctrl_t                   s2_ctrl_d;
  logic [3:0][2*WW-1:0]    s2_wp_d;
  logic [NN-1:0][2*NW-1:0] s2_np_d;

  always_comb begin
    s2_ctrl_d = pp_ctrl;
    s2_wp_d   = wp;
    s2_np_d   = np;
    if (s1_valid_q) begin
      s2_ctrl_d = s1_ctrl_q;
      s2_wp_d   = wp_c;
      s2_np_d   = np_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_valid <= 1'b0;
      pp_ctrl  <= '0;
      wp       <= '0;
      np       <= '0;
    end else begin
      pp_valid <= s1_valid_q;
      pp_ctrl  <= s2_ctrl_d;
      wp       <= s2_wp_d;
      np       <= s2_np_d;
    end
  end

  // unsigned operands give non-negative wide products (R5)
  for (genvar w = 0; w < 4; w++) begin : g_chk_w
    assert_unsigned_nonneg_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && !pp_ctrl.sgn) |-> !wp[w][2*WW-1])
      else $error("unsigned wide product %0d negative", w);
  end

  // byte products fit in 16 bits, so no element needs more (R4)
  for (genvar n = 0; n < NN; n++) begin : g_chk_n
    assert_byte_fits_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && is_byte(pp_ctrl.mode)) |->
        (pp_ctrl.sgn ? (np[n][2*NW-1:2*NW-3] == 3'b000 || np[n][2*NW-1:2*NW-3] == 3'b111)
                     : (np[n][2*NW-1:2*NW-2] == 2'b00)))
      else $error("byte product %0d exceeds element range", n);
  end

endmodule

// File: rtl/smul_combine.sv
module smul_combine
  import simd_mul_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int WW = WIDE_W,
  parameter int NW = NARROW_W,
  parameter int NN = NARROW_N
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pp_valid,
  input  ctrl_t                   pp_ctrl,
  input  logic [3:0][2*WW-1:0]    wp,
  input  logic [NN-1:0][2*NW-1:0] np,
  output logic                    res_valid,
  output logic [LW-1:0]           res
);
  localparam int DW = 2 * LW;
  localparam int HW = LW / 2;
  localparam int BW = LW / 4;

  function automatic logic [DW-1:0] sx(logic [2*WW-1:0] v);
    return {{(DW-2*WW){v[2*WW-1]}}, v};
  endfunction

  logic [DW-1:0]          word_p;
  logic [1:0][LW-1:0]     half_p;
  logic [3:0][2*BW-1:0]   byte_p;
  logic [LW-1:0]          res_c, res_d;

  always_comb begin
    word_p = sx(wp[0]) + ((sx(wp[1]) + sx(wp[2])) << HW) + (sx(wp[3]) << LW);
    half_p[0] = wp[0][LW-1:0];
    half_p[1] = wp[3][LW-1:0];
    byte_p[0] = wp[0][2*BW-1:0];
    byte_p[1] = wp[1][2*BW-1:0];
    for (int i = 0; i < NN; i++) byte_p[2+i] = np[i][2*BW-1:0];
  end

  always_comb begin
    res_c = '0;
    unique case (pp_ctrl.mode)
      MODE_WORD: res_c = pp_ctrl.hi ? word_p[DW-1:LW] : word_p[LW-1:0];
      MODE_HALF: begin
        for (int i = 0; i < 2; i++)
          res_c[i*HW +: HW] = pp_ctrl.hi ? half_p[i][LW-1:HW] : half_p[i][HW-1:0];
      end
      default: begin
        for (int i = 0; i < 4; i++)
          res_c[i*BW +: BW] = pp_ctrl.hi ? byte_p[i][2*BW-1:BW] : byte_p[i][BW-1:0];
      end
    endcase
  end

  always_comb begin
    res_d = res;
    if (pp_valid) res_d = res_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= pp_valid;
      res       <= res_d;
    end
  end

  assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !pp_valid |=> $stable(res))
    else $error("result changed without a new product");

endmodule

// File: rtl/simd_mul_lane.sv
module simd_mul_lane
  import simd_mul_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int WW = WIDE_W,
  parameter int NW = NARROW_W,
  parameter int NN = NARROW_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [LW-1:0] in_a,
  input  logic [LW-1:0] in_b,
  input  logic [1:0]    in_mode,
  input  logic          in_signed,
  input  logic          in_high,
  output logic          out_valid,
  output logic [LW-1:0] out_result
);
  ctrl_t                   ctrl;
  logic [3:0][WW-1:0]      wa, wb;
  logic [NN-1:0][NW-1:0]   na, nb;
  logic                    pp_valid;
  ctrl_t                   pp_ctrl;
  logic [3:0][2*WW-1:0]    wp;
  logic [NN-1:0][2*NW-1:0] np;

  assign ctrl.mode = mode_e'(in_mode);
  assign ctrl.sgn  = in_signed;
  assign ctrl.hi   = in_high;

  smul_operand_prep #(.LW(LW), .WW(WW), .NW(NW), .NN(NN)) u_prep (
    .a    (in_a),
    .b    (in_b),
    .ctrl (ctrl),
    .wa   (wa),
    .wb   (wb),
    .na   (na),
    .nb   (nb)
  );

  smul_partial_products #(.WW(WW), .NW(NW), .NN(NN)) u_pp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ctrl  (ctrl),
    .wa       (wa),
    .wb       (wb),
    .na       (na),
    .nb       (nb),
    .pp_valid (pp_valid),
    .pp_ctrl  (pp_ctrl),
    .wp       (wp),
    .np       (np)
  );

  smul_combine #(.LW(LW), .WW(WW), .NW(NW), .NN(NN)) u_comb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pp_valid  (pp_valid),
    .pp_ctrl   (pp_ctrl),
    .wp        (wp),
    .np        (np),
    .res_valid (out_valid),
    .res       (out_result)
  );

  assert_latency_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid)
    else $error("accepted operands produced no result after 3 edges");

endmodule

// File: tb/simd_mul_lane_test.sv
module simd_mul_lane_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_a, in_b;
  logic [1:0]  in_mode;
  logic        in_signed, in_high;
  logic        out_valid;
  logic [31:0] out_result;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  simd_mul_lane uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_mode(in_mode), .in_signed(in_signed), .in_high(in_high),
    .out_valid(out_valid), .out_result(out_result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] ref_mul(logic [31:0] a, logic [31:0] b,
                                          logic [1:0] mode, logic sgn, logic hi);
    int w = (mode == 2'd0) ? 32 : (mode == 2'd1) ? 16 : 8;
    logic [63:0] mask = (64'd1 << w) - 64'd1;
    logic [31:0] r = '0;
    for (int e = 0; e < 32 / w; e++) begin
      logic [63:0] ea, eb, p;
      ea = (64'(a) >> (e * w)) & mask;
      eb = (64'(b) >> (e * w)) & mask;
      if (sgn && ea[w-1]) ea = ea | ~mask;
      if (sgn && eb[w-1]) eb = eb | ~mask;
      p = ea * eb;
      if (hi) p = p >> w;
      r = r | 32'((p & mask) << (e * w));
    end
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] mode, logic sgn, logic hi);
    string t;
    if (mode == 2'd0) t = hi ? "R2" : "R1";
    else if (mode == 2'd1) t = "R3";
    else t = "R4";
    if (sgn) t = {t, "/R5"};
    if (hi && mode != 2'd0) t = {t, "/R6"};
    return t;
  endfunction

  // three-deep reference pipeline
  logic        pv [3];
  logic [31:0] pr [3];
  string       pt [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin pv[i] <= 1'b0; pr[i] <= '0; pt[i] <= ""; end
    end else begin
      pv[2] <= pv[1]; pr[2] <= pr[1]; pt[2] <= pt[1];
      pv[1] <= pv[0]; pr[1] <= pr[0]; pt[1] <= pt[0];
      pv[0] <= in_valid;
      pr[0] <= in_valid ? ref_mul(in_a, in_b, in_mode, in_signed, in_high) : 32'd0;
      pt[0] <= tag_of(in_mode, in_signed, in_high);
    end
  end

  logic [31:0] last_res;
  bit          checking = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      total++;
      if (out_valid !== 1'b0 || out_result !== 32'd0) begin
        bad++;
        $display("FAIL R8 reset: valid=%0b result=%h expected valid=0 result=00000000",
                 out_valid, out_result);
      end
      last_res = 32'd0;
    end else if (checking) begin
      total++;
      if (out_valid !== pv[2]) begin
        bad++;
        $display("FAIL R7 out_valid=%0b expected %0b", out_valid, pv[2]);
      end
      if (pv[2]) begin
        total++;
        if (out_result !== pr[2]) begin
          bad++;
          $display("FAIL %s result=%h expected %h", pt[2], out_result, pr[2]);
        end
        last_res = pr[2];
      end else begin
        total++;
        if (out_result !== last_res) begin
          bad++;
          $display("FAIL R9 hold result=%h expected %h", out_result, last_res);
        end
      end
    end
  end

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [1:0] m, logic s, logic h);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_mode = m; in_signed = s; in_high = h;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_a = $urandom; in_b = $urandom;
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    in_mode = '0; in_signed = 1'b0; in_high = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checking = 1;
    idle(2);
    // R1/R2 word mode
    drive(32'd12345, 32'd6789, 2'd0, 1'b0, 1'b0);
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b1);
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 1'b1, 1'b1);
    drive(32'h8000_0000, 32'h8000_0000, 2'd0, 1'b1, 1'b1);
    drive(32'h8000_0000, 32'h7FFF_FFFF, 2'd0, 1'b1, 1'b0);
    drive(32'h1234_5678, 32'h9ABC_DEF0, 2'd0, 1'b1, 1'b1);
    // R3 halfword: carries must not cross
    drive(32'h0001_FFFF, 32'h0001_FFFF, 2'd1, 1'b0, 1'b0);
    drive(32'h0001_FFFF, 32'h0001_FFFF, 2'd1, 1'b0, 1'b1);
    drive(32'h8000_8000, 32'h8000_7FFF, 2'd1, 1'b1, 1'b1);
    drive(32'hFFFF_0003, 32'h0002_FFFF, 2'd1, 1'b1, 1'b0);
    // R4 byte, both codes
    drive(32'h80FF_7F01, 32'h80FF_7F01, 2'd2, 1'b1, 1'b1);
    drive(32'h80FF_7F01, 32'h80FF_7F01, 2'd3, 1'b1, 1'b1);
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 1'b0, 1'b1);
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1'b0, 1'b0);
    drive(32'h0302_0100, 32'h0405_0607, 2'd2, 1'b0, 1'b0);
    idle(4);
    // random traffic with gaps
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(3) == 0) idle(1 + $urandom_range(2));
      drive($urandom, $urandom, 2'($urandom_range(3)), 1'($urandom), 1'($urandom));
    end
    idle(6);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R7 watchdog expired: running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule